// File: doc/BRIEF.md
# Debug Abstract Command Sequencer

This block takes a 32-bit command word written by an external debugger and carries it out against one selected processor hart. The hart sits behind a simple request/acknowledge port. The sequencer decodes the word and refuses option combinations it cannot honour. It moves argument words from a small bank of 32-bit data registers toward the hart, and writes results back into that bank before it reports completion. When the command asks for it, the block also starts one run of a short program buffer on the hart once the register access has finished.

Progress and outcome are reported through a busy flag and a 3-bit error code. The error code latches the first failure. While it is nonzero the sequencer refuses every further command, so that a run of commands written back to back never executes past a failing one. The debugger reads the code, clears it by writing ones to its bits, and then continues. The sequencer only addresses the hart picked by the single-hart index upstream; any multi-hart selection is not its concern.

Command word layout used here: bits [31:24] command type (0x00 = register access, every other type is unsupported), bits [23:21] reserved and required to be zero, bit 20 write, bit 19 transfer, bit 18 run-program-after, bits [17:16] size code (2 = 32-bit, 3 = 64-bit, other codes unsupported), bits [15:0] register number.

Top module: `abstract_cmd_seq`

## Requirements
- R1: After reset, busy is 0, the error code is 0, no hart request is raised and every data register reads 0.
- R2: A command written while idle with error code 0 is accepted, and busy reads 1 in the cycle after the write.
- R3: A command whose type is not 0x00, whose reserved bits [23:21] are not zero, whose size code is not 2 or 3, or that asks for a program run when no program buffer is present, sets the error code to 2, makes no hart request and ends with busy low.
- R4: A register read (transfer 1, write 0) places the hart's result into the data registers before busy falls: a 32-bit read fills data register 0 and leaves register 1 untouched; a 64-bit read puts the low word in register 0 and the high word in register 1.
- R5: A register write (transfer 1, write 1) presents data register 0 as the value's low word and, for size code 3, data register 1 as its high word, with the write strobe and the 64-bit flag raised.
- R6: With run-program-after set, exactly one program-buffer run is requested after the register access completes; with transfer 0 only the program run takes place.
- R7: An exception reported with the hart's acknowledge sets the error code to 3, ends the command with busy low, and no program run follows.
- R8: If the hart is unavailable when the command starts, or becomes unavailable while a request is outstanding, the command ends with busy low, the hart request dropped and error code 4.
- R9: A command written while busy is ignored and sets the error code to 1 if it was 0; the command in flight still completes.
- R10: While the error code is nonzero, a written command is not executed: busy stays low and no hart request is made.
- R11: Writing the error-clear strobe clears each error bit whose mask bit is 1 and leaves the other bits unchanged.
- R12: Debugger writes to the data registers while busy have no effect.
- R13: A hart request, once raised, keeps its kind and register number stable until acknowledged or until the hart becomes unavailable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| err_clr_wr | input | 1 | Error clear strobe |
| err_clr_mask | input | 3 | Error bits to clear (1 clears) |
| dat_wr | input | 1 | Data register write strobe |
| dat_widx | input | IDX_W | Data register write index |
| dat_wdata | input | DATA_W | Data register write value |
| dat_ridx | input | IDX_W | Data register read index |
| dat_rdata | output | DATA_W | Data register read value |
| busy | output | 1 | Command in progress |
| cmd_err | output | 3 | Sticky error code |
| hart_req | output | 1 | Request toward the hart |
| hart_kind | output | 1 | 0 register access, 1 program-buffer run |
| hart_we | output | 1 | Register access is a write |
| hart_wide | output | 1 | Register access is 64-bit |
| hart_regno | output | 16 | Register number |
| hart_wdata | output | 2*DATA_W | Write value, low word from data register 0 |
| hart_ack | input | 1 | Hart completes the request |
| hart_exc | input | 1 | Exception, valid with hart_ack |
| hart_avail | input | 1 | Hart is available |
| hart_rdata | input | 2*DATA_W | Read result, valid with hart_ack |

## Verification
The assertions assume that the hart raises acknowledge only while a request is outstanding, for one cycle, and that exception is meaningful only alongside acknowledge. They also assume that clear strobes and command strobes are single-cycle pulses sampled on the clock. The bench's hart model follows exactly this: it counts a configurable latency while the request is high and the hart is available, then pulses acknowledge once with the exception flag chosen per request kind. All stimulus is applied on the falling edge, so every strobe is seen by exactly one rising edge.

// File: rtl/dbgcmd_pkg.sv
package dbgcmd_pkg;
  localparam int CMD_W   = 32;
  localparam int REGNO_W = 16;

  localparam logic [7:0] TYPE_REGACC = 8'h00;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_BUSY  = 3'd1;
  localparam logic [2:0] ERR_UNSUP = 3'd2;
  localparam logic [2:0] ERR_EXC   = 3'd3;
  localparam logic [2:0] ERR_AVAIL = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_XFER   = 2'd2,
    ST_PROG   = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic               opts_ok;
    logic               write;
    logic               xfer;
    logic               post;
    logic               wide;
    logic [REGNO_W-1:0] regno;
  } cmd_fields_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import dbgcmd_pkg::*;
#(
  parameter bit HAS_PROG = 1'b1,
  parameter bit HAS_WIDE = 1'b1
) (
  input  logic [CMD_W-1:0] word,
  output cmd_fields_t      fields
);
  logic [7:0] ctype;
  logic [2:0] rsvd;
  logic [1:0] size;
  logic       type_ok;
  logic       rsvd_ok;
  logic       size_ok;
  logic       post_ok;

  always_comb begin
    ctype   = word[31:24];
    rsvd    = word[23:21];
    size    = word[17:16];
    type_ok = (ctype == TYPE_REGACC);
    rsvd_ok = (rsvd == 3'b000);
    size_ok = (size == 2'd2) || ((size == 2'd3) && HAS_WIDE);
    post_ok = !word[18] || HAS_PROG;

    fields.opts_ok = type_ok && rsvd_ok && size_ok && post_ok;
    fields.write   = word[20];
    fields.xfer    = word[19];
    fields.post    = word[18];
    fields.wide    = (size == 2'd3);
    fields.regno   = word[REGNO_W-1:0];
  end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import dbgcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  cmd_fields_t cmd_f,
  input  logic        err_clr_wr,
  input  logic [2:0]  err_clr_mask,
  input  logic        hart_ack,
  input  logic        hart_exc,
  input  logic        hart_avail,
  output seq_state_e  state,
  output cmd_fields_t cur,
  output logic [2:0]  err,
  output logic        res_we
);
  seq_state_e  state_n;
  cmd_fields_t cur_n;
  logic        cur_en;
  logic [2:0]  err_n;
  logic [2:0]  set_code;

  always_comb begin
    state_n  = state;
    cur_n    = cmd_f;
    cur_en   = 1'b0;
    set_code = ERR_NONE;
    res_we   = 1'b0;
    err_n    = err & ~(err_clr_wr ? err_clr_mask : 3'b000);

    case (state)
      ST_IDLE: begin
        if (cmd_wr && (err == ERR_NONE)) begin
          cur_en  = 1'b1;
          state_n = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (!cur.opts_ok) begin
          set_code = ERR_UNSUP;
          state_n  = ST_IDLE;
        end else if (!hart_avail) begin
          set_code = ERR_AVAIL;
          state_n  = ST_IDLE;
        end else if (cur.xfer) begin
          state_n = ST_XFER;
        end else if (cur.post) begin
          state_n = ST_PROG;
        end else begin
          state_n = ST_IDLE;
        end
      end
      ST_XFER: begin
        if (!hart_avail) begin
          set_code = ERR_AVAIL;
          state_n  = ST_IDLE;
        end else if (hart_ack) begin
          if (hart_exc) begin
            set_code = ERR_EXC;
            state_n  = ST_IDLE;
          end else begin
            res_we  = !cur.write;
            state_n = cur.post ? ST_PROG : ST_IDLE;
          end
        end
      end
      ST_PROG: begin
        if (!hart_avail) begin
          set_code = ERR_AVAIL;
          state_n  = ST_IDLE;
        end else if (hart_ack) begin
          if (hart_exc) set_code = ERR_EXC;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase

    if (err == ERR_NONE) begin
      if (set_code != ERR_NONE) err_n = set_code;
      else if (cmd_wr && (state != ST_IDLE)) err_n = ERR_BUSY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      err   <= ERR_NONE;
    end else begin
      state <= state_n;
      err   <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (cur_en) begin
      cur <= cur_n;
    end
  end
endmodule

// File: rtl/data_regs.sv
module data_regs #(
  parameter int N_DATA = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N_DATA > 1) ? $clog2(N_DATA) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_we,
  input  logic [IDX_W-1:0]    host_idx,
  input  logic [DATA_W-1:0]   host_wdata,
  input  logic                res_we,
  input  logic                res_wide,
  input  logic [2*DATA_W-1:0] res_data,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [DATA_W-1:0]   rd_data,
  output logic [DATA_W-1:0]   word0,
  output logic [DATA_W-1:0]   word1
);
  logic [N_DATA-1:0][DATA_W-1:0] bank;

  for (genvar i = 0; i < N_DATA; i++) begin : g_word
    logic              en;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] q;
    logic              res_hit;

    always_comb begin
      if (i == 0)      res_hit = res_we;
      else if (i == 1) res_hit = res_we && res_wide;
      else             res_hit = 1'b0;
      en = res_hit || (host_we && (host_idx == IDX_W'(i)));
      if (res_hit) d = (i == 0) ? res_data[DATA_W-1:0] : res_data[2*DATA_W-1:DATA_W];
      else         d = host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign bank[i] = q;
  end

  assign rd_data = bank[rd_idx];
  assign word0   = bank[0];
  assign word1   = bank[1];
endmodule

// File: rtl/abstract_cmd_seq.sv
module abstract_cmd_seq
  import dbgcmd_pkg::*;
#(
  parameter int N_DATA   = 4,
  parameter int DATA_W   = 32,
  parameter bit HAS_PROG = 1'b1,
  parameter bit HAS_WIDE = 1'b1,
  localparam int IDX_W   = (N_DATA > 1) ? $clog2(N_DATA) : 1,
  localparam int WIDE_W  = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_word,
  input  logic               err_clr_wr,
  input  logic [2:0]         err_clr_mask,
  input  logic               dat_wr,
  input  logic [IDX_W-1:0]   dat_widx,
  input  logic [DATA_W-1:0]  dat_wdata,
  input  logic [IDX_W-1:0]   dat_ridx,
  output logic [DATA_W-1:0]  dat_rdata,
  output logic               busy,
  output logic [2:0]         cmd_err,
  output logic               hart_req,
  output logic               hart_kind,
  output logic               hart_we,
  output logic               hart_wide,
  output logic [REGNO_W-1:0] hart_regno,
  output logic [WIDE_W-1:0]  hart_wdata,
  input  logic               hart_ack,
  input  logic               hart_exc,
  input  logic               hart_avail,
  input  logic [WIDE_W-1:0]  hart_rdata
);
  logic [1:0]  rst_sync;
  logic        rst_int_n;
  cmd_fields_t dec_f;
  cmd_fields_t cur;
  seq_state_e  state;
  logic        res_we;
  logic [DATA_W-1:0] word0;
  logic [DATA_W-1:0] word1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  cmd_decode #(.HAS_PROG(HAS_PROG), .HAS_WIDE(HAS_WIDE)) u_dec (
    .word   (cmd_word),
    .fields (dec_f)
  );

  cmd_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cmd_wr       (cmd_wr),
    .cmd_f        (dec_f),
    .err_clr_wr   (err_clr_wr),
    .err_clr_mask (err_clr_mask),
    .hart_ack     (hart_ack),
    .hart_exc     (hart_exc),
    .hart_avail   (hart_avail),
    .state        (state),
    .cur          (cur),
    .err          (cmd_err),
    .res_we       (res_we)
  );

  assign busy = (state != ST_IDLE);

  data_regs #(.N_DATA(N_DATA), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .host_we    (dat_wr && !busy),
    .host_idx   (dat_widx),
    .host_wdata (dat_wdata),
    .res_we     (res_we),
    .res_wide   (cur.wide),
    .res_data   (hart_rdata),
    .rd_idx     (dat_ridx),
    .rd_data    (dat_rdata),
    .word0      (word0),
    .word1      (word1)
  );

  assign hart_req   = (state == ST_XFER) || (state == ST_PROG);
  assign hart_kind  = (state == ST_PROG);
  assign hart_we    = (state == ST_XFER) && cur.write;
  assign hart_wide  = cur.wide;
  assign hart_regno = cur.regno;
  assign hart_wdata = cur.wide ? {word1, word0} : {{DATA_W{1'b0}}, word0};
endmodule

// File: rtl/dbgcmd_checker.sv
module dbgcmd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic        err_clr_wr,
  input logic [2:0]  err_clr_mask,
  input logic        busy,
  input logic [2:0]  cmd_err,
  input logic        hart_req,
  input logic        hart_kind,
  input logic [15:0] hart_regno,
  input logic        hart_ack,
  input logic        hart_exc,
  input logic        hart_avail
);
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && cmd_err == 3'd0) |=> busy); // R2

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !hart_req); // R10

  AST_EXC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (hart_req && hart_ack && hart_avail && hart_exc && cmd_err == 3'd0)
      |=> (cmd_err == 3'd3 && !busy)); // R7

  AST_UNAVAIL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (hart_req && !hart_avail && cmd_err == 3'd0)
      |=> (cmd_err == 3'd4 && !busy && !hart_req)); // R8

  AST_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy && cmd_err == 3'd0) |=> (cmd_err != 3'd0)); // R9

  AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && cmd_err != 3'd0) |=> !busy); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err != 3'd0 && !(err_clr_wr && ((err_clr_mask & cmd_err) != 3'd0)))
      |=> $stable(cmd_err)); // R11

  AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_wr && cmd_err != 3'd0)
      |=> (cmd_err == ($past(cmd_err) & ~$past(err_clr_mask)))); // R11

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hart_req && !hart_ack && hart_avail)
      |=> (hart_req && $stable(hart_kind) && $stable(hart_regno))); // R13
endmodule

bind abstract_cmd_seq dbgcmd_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_wr       (cmd_wr),
  .err_clr_wr   (err_clr_wr),
  .err_clr_mask (err_clr_mask),
  .busy         (busy),
  .cmd_err      (cmd_err),
  .hart_req     (hart_req),
  .hart_kind    (hart_kind),
  .hart_regno   (hart_regno),
  .hart_ack     (hart_ack),
  .hart_exc     (hart_exc),
  .hart_avail   (hart_avail)
);

// File: tb/sim_abstract_cmd_seq.sv
`timescale 1ns/1ps
module sim_abstract_cmd_seq;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        cmd_wr;
  logic [31:0] cmd_word;
  logic        err_clr_wr;
  logic [2:0]  err_clr_mask;
  logic        dat_wr;
  logic [1:0]  dat_widx;
  logic [31:0] dat_wdata;
  logic [1:0]  dat_ridx;
  logic [31:0] dat_rdata;
  logic        busy;
  logic [2:0]  cmd_err;
  logic        hart_req;
  logic        hart_kind;
  logic        hart_we;
  logic        hart_wide;
  logic [15:0] hart_regno;
  logic [63:0] hart_wdata;
  logic        hart_ack;
  logic        hart_exc;
  logic        hart_avail;
  logic [63:0] hart_rdata;

  int checks;
  int errors;

  logic [63:0] mdl [16];
  int  reg_ops;
  int  prog_ops;
  int  lat;
  int  lat_cnt;
  bit  exc_reg;
  bit  exc_prog;

  abstract_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .err_clr_wr(err_clr_wr), .err_clr_mask(err_clr_mask),
    .dat_wr(dat_wr), .dat_widx(dat_widx), .dat_wdata(dat_wdata),
    .dat_ridx(dat_ridx), .dat_rdata(dat_rdata),
    .busy(busy), .cmd_err(cmd_err),
    .hart_req(hart_req), .hart_kind(hart_kind), .hart_we(hart_we),
    .hart_wide(hart_wide), .hart_regno(hart_regno), .hart_wdata(hart_wdata),
    .hart_ack(hart_ack), .hart_exc(hart_exc), .hart_avail(hart_avail),
    .hart_rdata(hart_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Hart model: acknowledges after lat cycles of an outstanding request
  always @(negedge clk) begin
    if (!rst_n) begin
      hart_ack <= 1'b0; hart_exc <= 1'b0; hart_rdata <= '0; lat_cnt <= 0;
    end else if (hart_ack) begin
      hart_ack <= 1'b0; hart_exc <= 1'b0;
    end else if (hart_req && hart_avail) begin
      if (lat_cnt >= lat) begin
        lat_cnt  <= 0;
        hart_ack <= 1'b1;
        if (hart_kind) begin
          prog_ops <= prog_ops + 1;
          hart_exc <= exc_prog;
        end else begin
          reg_ops    <= reg_ops + 1;
          hart_exc   <= exc_reg;
          hart_rdata <= mdl[hart_regno[3:0]];
          if (hart_we && !exc_reg) begin
            if (hart_wide) mdl[hart_regno[3:0]] <= hart_wdata;
            else mdl[hart_regno[3:0]][31:0] <= hart_wdata[31:0];
          end
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      lat_cnt <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] ty, input bit wr, input bit xf,
                                     input bit po, input logic [1:0] sz, input logic [15:0] rn);
    return {ty, 3'b000, wr, xf, po, sz, rn};
  endfunction

  task automatic write_cmd(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_word = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 500) begin @(negedge clk); n++; end
    if (n >= 500) chk(1'b0, "wait_idle timeout", 64'(busy), 64'd0);
  endtask

  task automatic clr_err(input logic [2:0] m);
    @(negedge clk); err_clr_wr = 1'b1; err_clr_mask = m;
    @(negedge clk); err_clr_wr = 1'b0; err_clr_mask = '0;
  endtask

  task automatic wr_data(input logic [1:0] idx, input logic [31:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_widx = idx; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic rd_data(input logic [1:0] idx, output logic [31:0] v);
    dat_ridx = idx; #1; v = dat_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
    chk(cmd_err == 3'd0, "R1 err after reset", 64'(cmd_err), 64'd0);
    chk(hart_req == 1'b0, "R1 req after reset", 64'(hart_req), 64'd0);
    for (int i = 0; i < 4; i++) begin
      rd_data(2'(i), v);
      chk(v == 32'd0, "R1 data reg after reset", 64'(v), 64'd0);
    end
  endtask

  task automatic t_read();
    logic [31:0] v;
    int r0;
    mdl[5] = 64'hAAAA_BBBB_1111_2222;
    mdl[6] = 64'hCAFE_F00D_0BAD_BEEF;
    wr_data(2'd1, 32'h0000_DEAD);
    r0 = reg_ops;
    write_cmd(mk(8'h00, 1'b0, 1'b1, 1'b0, 2'd2, 16'd5));
    chk(busy == 1'b1, "R2 busy after accepted write", 64'(busy), 64'd1);
    wait_idle();
    rd_data(2'd0, v); chk(v == 32'h1111_2222, "R4 32-bit read data0", 64'(v), 64'h1111_2222);
    rd_data(2'd1, v); chk(v == 32'h0000_DEAD, "R4 32-bit read leaves data1", 64'(v), 64'hDEAD);
    chk(reg_ops == r0 + 1, "R4 one register access", 64'(reg_ops), 64'(r0 + 1));
    write_cmd(mk(8'h00, 1'b0, 1'b1, 1'b0, 2'd3, 16'd6));
    wait_idle();
    rd_data(2'd0, v); chk(v == 32'h0BAD_BEEF, "R4 64-bit read low word", 64'(v), 64'h0BAD_BEEF);
    rd_data(2'd1, v); chk(v == 32'hCAFE_F00D, "R4 64-bit read high word", 64'(v), 64'hCAFE_F00D);
    chk(cmd_err == 3'd0, "R4 no error", 64'(cmd_err), 64'd0);
  endtask

  task automatic t_write();
    mdl[7] = 64'h5555_5555_0000_0000;
    wr_data(2'd0, 32'h1234_5678);
    write_cmd(mk(8'h00, 1'b1, 1'b1, 1'b0, 2'd2, 16'd7));
    wait_idle();
    chk(mdl[7] == 64'h5555_5555_1234_5678, "R5 32-bit write", mdl[7], 64'h5555_5555_1234_5678);
    wr_data(2'd1, 32'h9ABC_DEF0);
    write_cmd(mk(8'h00, 1'b1, 1'b1, 1'b0, 2'd3, 16'd8));
    wait_idle();
    chk(mdl[8] == 64'h9ABC_DEF0_1234_5678, "R5 64-bit write", mdl[8], 64'h9ABC_DEF0_1234_5678);
  endtask

  task automatic t_postexec();
    int r0, p0;
    r0 = reg_ops; p0 = prog_ops;
    write_cmd(mk(8'h00, 1'b0, 1'b1, 1'b1, 2'd2, 16'd5));
    wait_idle();
    chk(reg_ops == r0 + 1, "R6 register access before program", 64'(reg_ops), 64'(r0 + 1));
    chk(prog_ops == p0 + 1, "R6 one program run", 64'(prog_ops), 64'(p0 + 1));
    write_cmd(mk(8'h00, 1'b0, 1'b0, 1'b1, 2'd2, 16'd0));
    wait_idle();
    chk(reg_ops == r0 + 1, "R6 program only: no register access", 64'(reg_ops), 64'(r0 + 1));
    chk(prog_ops == p0 + 2, "R6 program only: one run", 64'(prog_ops), 64'(p0 + 2));
    chk(cmd_err == 3'd0, "R6 no error", 64'(cmd_err), 64'd0);
  endtask

  task automatic t_unsupported();
    int r0, p0;
    r0 = reg_ops; p0 = prog_ops;
    write_cmd(mk(8'h05, 1'b0, 1'b1, 1'b0, 2'd2, 16'd5));
    wait_idle();
    chk(cmd_err == 3'd2, "R3 unknown type", 64'(cmd_err), 64'd2);
    clr_err(3'b010);
    chk(cmd_err == 3'd0, "R11 clear of code 2", 64'(cmd_err), 64'd0);
    write_cmd(mk(8'h00, 1'b0, 1'b1, 1'b0, 2'd1, 16'd5));
    wait_idle();
    chk(cmd_err == 3'd2, "R3 bad size code", 64'(cmd_err), 64'd2);
    clr_err(3'b111);
    write_cmd(mk(8'h00, 1'b0, 1'b1, 1'b0, 2'd2, 16'd5) | 32'h0040_0000);
    wait_idle();
    chk(cmd_err == 3'd2, "R3 reserved bit set", 64'(cmd_err), 64'd2);
    chk(reg_ops == r0 && prog_ops == p0, "R3 no hart action", 64'(reg_ops + prog_ops), 64'(r0 + p0));
    clr_err(3'b111);
  endtask

  task automatic t_exception();
    int p0;
    exc_prog = 1'b1;
    write_cmd(mk(8'h00, 1'b0, 1'b1, 1'b1, 2'd2, 16'd5));
    wait_idle();
    chk(cmd_err == 3'd3, "R7 program exception", 64'(cmd_err), 64'd3);
    clr_err(3'b001);
    chk(cmd_err == 3'd2, "R11 partial clear keeps bit 1", 64'(cmd_err), 64'd2);
    clr_err(3'b010);
    exc_prog = 1'b0; exc_reg = 1'b1;
    p0 = prog_ops;
    write_cmd(mk(8'h00, 1'b0, 1'b1, 1'b1, 2'd2, 16'd5));
    wait_idle();
    chk(cmd_err == 3'd3, "R7 register exception", 64'(cmd_err), 64'd3);
    chk(prog_ops == p0, "R7 no program after exception", 64'(prog_ops), 64'(p0));
    exc_reg = 1'b0;
    clr_err(3'b111);
  endtask

  task automatic t_unavail();
    int r0;
    r0 = reg_ops;
    hart_avail = 1'b0;
    write_cmd(mk(8'h00, 1'b0, 1'b1, 1'b0, 2'd2, 16'd5));
    wait_idle();
    chk(cmd_err == 3'd4, "R8 unavailable at start", 64'(cmd_err), 64'd4);
    chk(reg_ops == r0, "R8 no access at start", 64'(reg_ops), 64'(r0));
    hart_avail = 1'b1;
    clr_err(3'b100);
    lat = 20;
    write_cmd(mk(8'h00, 1'b0, 1'b1, 1'b0, 2'd2, 16'd5));
    @(negedge clk); @(negedge clk);
    chk(hart_req == 1'b1, "R8 request outstanding", 64'(hart_req), 64'd1);
    hart_avail = 1'b0;
    @(negedge clk);
    chk(cmd_err == 3'd4, "R8 unavailable mid-flight code", 64'(cmd_err), 64'd4);
    chk(!busy && !hart_req, "R8 busy and request dropped", 64'({busy, hart_req}), 64'd0);
    hart_avail = 1'b1;
    lat = 2;
    clr_err(3'b100);
  endtask

  task automatic t_busy_write();
    int r0, p0;
    logic [15:0] rn;
    logic [31:0] v;
    mdl[3] = 64'h0000_0000_3333_4444;
    wr_data(2'd2, 32'h0000_2222);
    r0 = reg_ops; p0 = prog_ops;
    lat = 6;
    write_cmd(mk(8'h00, 1'b0, 1'b1, 1'b0, 2'd2, 16'd3));
    @(negedge clk);
    rn = hart_regno;
    @(negedge clk);
    chk(hart_req && hart_regno == rn && !hart_kind, "R13 request held stable", 64'(hart_regno), 64'(rn));
    write_cmd(mk(8'h00, 1'b0, 1'b0, 1'b1, 2'd2, 16'd0));
    chk(cmd_err == 3'd1, "R9 write while busy", 64'(cmd_err), 64'd1);
    @(negedge clk); dat_wr = 1'b1; dat_widx = 2'd2; dat_wdata = 32'hBAD0_BAD0;
    @(negedge clk); dat_wr = 1'b0;
    wait_idle();
    rd_data(2'd0, v); chk(v == 32'h3333_4444, "R9 first command completes", 64'(v), 64'h3333_4444);
    chk(reg_ops == r0 + 1 && prog_ops == p0, "R9 second command ignored", 64'(prog_ops), 64'(p0));
    rd_data(2'd2, v); chk(v == 32'h0000_2222, "R12 data write while busy ignored", 64'(v), 64'h2222);
    lat = 2;
    // error still 1: next command must not run
    r0 = reg_ops;
    write_cmd(mk(8'h00, 1'b0, 1'b1, 1'b0, 2'd2, 16'd5));
    chk(busy == 1'b0, "R10 no start while error set", 64'(busy), 64'd0);
    repeat (10) @(negedge clk);
    chk(reg_ops == r0, "R10 no hart access while error set", 64'(reg_ops), 64'(r0));
    chk(cmd_err == 3'd1, "R10 error unchanged", 64'(cmd_err), 64'd1);
    clr_err(3'b001);
    write_cmd(mk(8'h00, 1'b0, 1'b1, 1'b0, 2'd2, 16'd5));
    wait_idle();
    chk(reg_ops == r0 + 1, "R10 runs again after clear", 64'(reg_ops), 64'(r0 + 1));
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    reg_ops = 0; prog_ops = 0; lat = 2; exc_reg = 1'b0; exc_prog = 1'b0;
    for (int i = 0; i < 16; i++) mdl[i] = 64'(i) * 64'h0101_0101_0101_0101;
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_word = '0; err_clr_wr = 1'b0; err_clr_mask = '0;
    dat_wr = 1'b0; dat_widx = '0; dat_wdata = '0; dat_ridx = '0; hart_avail = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_postexec();
    t_unsupported();
    t_exception();
    t_unavail();
    t_busy_write();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule